// File: doc/BRIEF.md
# Register Readiness Scoreboard with Wakeup Broadcast

This block keeps one readiness bit for every physical register that an instruction queue schedules against. Integer and floating-point registers share a single index space. Integer registers take the low indices, and floating-point registers follow directly after the last integer index.

When an instruction is dispatched as the producer of a register, that register's bit is cleared. This can happen even if the instruction never enters the issue queue itself. When the producing instruction completes, the bit is set again. On the following cycle the block broadcasts a one-cycle wakeup carrying the register index, so that every waiting consumer can be woken.

A set of source-query ports lets dispatch ask, for each source operand of a newly inserted instruction, whether the value is already available. If all of its sources report ready, the instruction can go straight to a ready queue. The bits must mirror the readiness held by the rename stage, so they all start ready after reset.

Top module: `rwb_top`

## Requirements
- R1: After reset every in-range register queries as ready (1) and `wakeValid` is 0.
- R2: Indices 0 to INT_REGS-1 are integer registers and INT_REGS to INT_REGS+FP_REGS-1 are floating point; with defaults, 96 and 191 are valid and behave like any other register.
- R3: A producer record (`recValid`=1, `recTag`=r) makes register r query as not ready (0) from the next rising edge on.
- R4: A completion (`compValid`=1, `compTag`=r) makes register r query as ready from the next rising edge on, leaving every other register unchanged.
- R5: A record and a completion naming the same register in one cycle leave that register not ready.
- R6: A query naming a register that is being completed in the same cycle returns ready in that cycle (bypass).
- R7: Each in-range completion produces exactly one cycle of `wakeValid`=1 with `wakeTag` equal to its index, one rising edge after the completion is presented.
- R8: Tags of INT_REGS+FP_REGS or above are ignored: a record or completion with such a tag changes no bit and emits no wakeup, and a query with such a tag returns 0.
- R9: Each query port reports the readiness of its own tag, independently of the other ports; port j uses bits j*TAG_W to j*TAG_W+TAG_W-1 of `qryTag` and bit j of `qryReady`.
- R10: A record and a completion naming different registers in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| recValid | input | 1 | Producer record strobe |
| recTag | input | TAG_W | Destination register index of the producer |
| compValid | input | 1 | Completion strobe |
| compTag | input | TAG_W | Register index whose value has arrived |
| qryTag | input | NUM_SRC*TAG_W | Packed source register indices, one field per port |
| qryReady | output | NUM_SRC | Readiness of each queried source register |
| wakeValid | output | 1 | Registered one-cycle wakeup pulse |
| wakeTag | output | TAG_W | Register index carried by the wakeup |

## Verification
Query results are combinational from the stored bits. A record or completion is therefore visible at `qryReady` one rising edge after it is presented, and a same-cycle completion bypass is visible before that edge. The wakeup pulse appears one rising edge after the completion is presented. The bench drives inputs on falling edges and samples queries shortly after driving, so it sees both the same-cycle bypass and the post-edge state. A monitor compares every falling-edge sample of the wakeup pins against a queue of expected wakeups, each stamped with the cycle in which it is due. Any wakeup that is early, late, extra or missing is therefore reported.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  // Strobes from control to the bit array, already qualified by range.
  typedef struct packed {
    logic recHit;
    logic compHit;
  } wakeStrb_t;

endpackage

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
  import rwb_pkg::*;
#(
  parameter int NUM_REGS = 192,
  parameter int TAG_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recValid,
  input  logic [TAG_W-1:0] recTag,
  input  logic             compValid,
  input  logic [TAG_W-1:0] compTag,
  output wakeStrb_t        strb,
  output logic             wakeValid,
  output logic [TAG_W-1:0] wakeTag
);

  localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_REGS);

  logic recInRange, compInRange;

  always_comb begin
    recInRange   = {1'b0, recTag}  < LIMIT;
    compInRange  = {1'b0, compTag} < LIMIT;
    strb.recHit  = recValid  && recInRange;
    strb.compHit = compValid && compInRange;
  end

  // Wakeup broadcast: registered, one cycle per completion.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeValid <= 1'b0;
      wakeTag   <= '0;
    end else begin
      wakeValid <= strb.compHit;
      wakeTag   <= strb.compHit ? compTag : wakeTag;
    end
  end

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.compHit |=> (wakeValid && wakeTag == $past(compTag)));

  p_no_stray_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.compHit |=> !wakeValid);

  p_wake_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> ({1'b0, wakeTag} < LIMIT));

endmodule

// File: rtl/rwb_bits.sv
module rwb_bits
  import rwb_pkg::*;
#(
  parameter int NUM_REGS = 192,
  parameter int TAG_W    = 8,
  parameter int NUM_SRC  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wakeStrb_t                strb,
  input  logic [TAG_W-1:0]         recTag,
  input  logic [TAG_W-1:0]         compTag,
  input  logic [NUM_SRC*TAG_W-1:0] qryTag,
  output logic [NUM_SRC-1:0]       qryReady
);

  localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_REGS);

  logic [NUM_REGS-1:0] rdy;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    logic recSel, compSel;
    assign recSel  = strb.recHit  && (recTag  == TAG_W'(i));
    assign compSel = strb.compHit && (compTag == TAG_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)        rdy[i] <= 1'b1;
      else if (recSel)  rdy[i] <= 1'b0;   // record takes precedence
      else if (compSel) rdy[i] <= 1'b1;
    end
  end

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_qry
    logic [TAG_W-1:0] tag;
    logic             inRange;
    assign tag     = qryTag[j*TAG_W +: TAG_W];
    assign inRange = {1'b0, tag} < LIMIT;
    always_comb begin
      qryReady[j] = 1'b0;
      if (inRange)
        qryReady[j] = rdy[tag] || (strb.compHit && compTag == tag);
    end
  end

  p_record_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.recHit |=> !rdy[$past(recTag)]);

  p_complete_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compHit && !(strb.recHit && recTag == compTag)) |=> rdy[$past(compTag)]);

  p_record_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recHit && strb.compHit && recTag == compTag) |=> !rdy[$past(compTag)]);

  p_quiet_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.recHit && !strb.compHit) |=> $stable(rdy));

endmodule

// File: rtl/rwb_top.sv
module rwb_top
  import rwb_pkg::*;
#(
  parameter int INT_REGS = 96,
  parameter int FP_REGS  = 96,
  parameter int NUM_SRC  = 2,
  localparam int NUM_REGS = INT_REGS + FP_REGS,
  localparam int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     recValid,
  input  logic [TAG_W-1:0]         recTag,
  input  logic                     compValid,
  input  logic [TAG_W-1:0]         compTag,
  input  logic [NUM_SRC*TAG_W-1:0] qryTag,
  output logic [NUM_SRC-1:0]       qryReady,
  output logic                     wakeValid,
  output logic [TAG_W-1:0]         wakeTag
);

  wakeStrb_t strb;

  rwb_ctrl #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .recValid(recValid), .recTag(recTag),
    .compValid(compValid), .compTag(compTag),
    .strb(strb), .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

  rwb_bits #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC)) u_bits (
    .clk(clk), .rstN(rstN), .strb(strb),
    .recTag(recTag), .compTag(compTag),
    .qryTag(qryTag), .qryReady(qryReady)
  );

endmodule

// File: tb/rwb_top_test.sv
module rwb_top_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NREG = 192;
  localparam int TW   = 8;
  localparam int NS   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recValid = 1'b0, compValid = 1'b0;
  logic [TW-1:0] recTag = '0, compTag = '0;
  logic [NS*TW-1:0] qryTag = '0;
  logic [NS-1:0] qryReady;
  logic wakeValid;
  logic [TW-1:0] wakeTag;

  rwb_top uut (
    .clk(clk), .rstN(rstN), .recValid(recValid), .recTag(recTag),
    .compValid(compValid), .compTag(compTag), .qryTag(qryTag),
    .qryReady(qryReady), .wakeValid(wakeValid), .wakeTag(wakeTag)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mdl [NREG];
  typedef struct {int due; int tag;} wakeExp_t;
  wakeExp_t wq[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: wakeup pins against the expectation queue (R7, R8).
  always @(negedge clk) begin
    if (rstN) begin
      bit due;
      due = (wq.size() > 0) && (wq[0].due == cyc);
      if (due || wakeValid) begin
        checks++;
        if (!(due && wakeValid && int'(wakeTag) == wq[0].tag)) begin
          errors++;
          $display("FAIL R7/R8 wake at cycle %0d: got valid=%b tag=%0d exp valid=%b tag=%0d",
                   cyc, wakeValid, wakeTag, due, due ? wq[0].tag : 0);
        end
        if (due) void'(wq.pop_front());
      end
    end
  end

  task automatic driveIn(bit rv, int rt, bit cv, int ct);
    recValid  = rv;  recTag  = TW'(rt);
    compValid = cv;  compTag = TW'(ct);
    if (cv && ct < NREG) wq.push_back('{due: cyc + 1, tag: ct});
  endtask

  task automatic clockIt();
    @(posedge clk);
    if (compValid && int'(compTag) < NREG) mdl[compTag] = 1'b1;
    if (recValid  && int'(recTag)  < NREG) mdl[recTag]  = 1'b0;
    @(negedge clk);
    recValid = 1'b0; compValid = 1'b0;
  endtask

  task automatic chkQry(int j, int tag, bit expv, string req);
    qryTag[j*TW +: TW] = TW'(tag);
    #0.4;
    checks++;
    if (qryReady[j] !== expv) begin
      errors++;
      $display("FAIL %s port %0d tag %0d: got %b exp %b", req, j, tag, qryReady[j], expv);
    end
  endtask

  function automatic bit mexp(int tag);
    return (tag < NREG) ? mdl[tag] : 1'b0;
  endfunction

  bit finished = 0;
  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R2 reset state, including integer/fp boundary indices
    chkQry(0, 0, 1'b1, "R1");
    chkQry(1, 95, 1'b1, "R2");
    chkQry(0, 96, 1'b1, "R2");
    chkQry(1, 191, 1'b1, "R1");
    checks++;
    if (wakeValid !== 1'b0) begin errors++; $display("FAIL R1 wakeValid got %b exp 0", wakeValid); end
    @(negedge clk);

    // R3 record clears; R9 other port unaffected
    driveIn(1, 5, 0, 0); clockIt();
    chkQry(0, 5, 1'b0, "R3");
    chkQry(1, 6, 1'b1, "R9");
    // R2 floating-point indices
    driveIn(1, 96, 0, 0); clockIt();
    driveIn(1, 191, 0, 0); clockIt();
    chkQry(0, 96, 1'b0, "R2");
    chkQry(1, 95, 1'b1, "R2");
    chkQry(0, 191, 1'b0, "R2");
    chkQry(1, 190, 1'b1, "R9");

    // R6 bypass in the completion cycle, R4 set afterwards
    driveIn(0, 0, 1, 5);
    chkQry(0, 5, 1'b1, "R6");
    chkQry(1, 96, 1'b0, "R6");
    clockIt();
    chkQry(0, 5, 1'b1, "R4");
    chkQry(1, 96, 1'b0, "R4");

    // R5 record and completion on the same register
    driveIn(1, 10, 1, 10); clockIt();
    chkQry(0, 10, 1'b0, "R5");

    // R10 record and completion on different registers
    driveIn(1, 20, 1, 96); clockIt();
    chkQry(0, 20, 1'b0, "R10");
    chkQry(1, 96, 1'b1, "R10");

    // R7 back-to-back completions, and completing an already-ready register
    driveIn(0, 0, 1, 20); clockIt();
    driveIn(0, 0, 1, 10); clockIt();
    driveIn(0, 0, 1, 0);  clockIt();
    chkQry(0, 20, 1'b1, "R7");
    chkQry(1, 10, 1'b1, "R7");

    // R8 out-of-range tags
    driveIn(1, 5, 0, 0); clockIt();
    driveIn(1, 200, 1, 250); clockIt();
    driveIn(0, 0, 1, 192); clockIt();
    chkQry(0, 200, 1'b0, "R8");
    chkQry(1, 255, 1'b0, "R8");
    repeat (3) @(negedge clk);

    // Full sweep over both ports: nothing outside the stimulus moved (R4, R8)
    for (int i = 0; i < NREG; i++) begin
      chkQry(i % NS, i, mexp(i), "R8");
      @(negedge clk);
    end

    checks++;
    if (wq.size() != 0) begin
      errors++;
      $display("FAIL R7 pending wakeups got %0d exp 0", wq.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule